// File: doc/BRIEF.md
# Synchronous Burst SRAM with Flow-Through Reads

This block is a small synchronous static memory built from four 9-bit byte lanes. Each lane holds eight data bits and one parity bit. It samples the address, write data, select inputs and burst controls on the rising clock edge. Read data leaves the array without an output register, so a read is visible in the cycle that follows the edge that sampled its address. The output drive is gated without delay by an output-enable input.

A burst begins on either of two address strobes: one meant for a processor and one meant for a memory controller. After that, a step input moves the two low address bits through a four-beat sequence. A static order input picks the sequence. Linear order adds the beat count to the start offset modulo 4. Interleaved order XORs the beat count with the start offset. The sequence wraps within its group of four words and never changes the upper address bits.

A small state machine tracks whether the device is idle, reading or writing. Its states are ST_IDLE, ST_READ and ST_WRITE. The transitions are:
- From ST_IDLE, a selected strobe enters ST_WRITE if the cycle writes, otherwise ST_READ. With no selected strobe, the machine stays in ST_IDLE.
- From ST_READ or ST_WRITE, a strobe taken while any select is inactive returns to ST_IDLE.
- Any other cycle moves to ST_WRITE or ST_READ according to the write controls of that cycle.

Top module: `sbs_top`

## Requirements
- R1: Address, write data, selects and burst controls are taken at the rising clock edge. Read data for the sampled address appears on `rd_data` in the cycle after that edge, with no further register stage.
- R2: The device is selected only when `sel_a_n` is 0, `sel_b` is 1 and `sel_c_n` is 0. A controller strobe (`strb_ctl_n` = 0) taken while any select is inactive moves the block to idle, and `rd_en` stays 0 until a new selected strobe arrives.
- R3: A processor strobe (`strb_cpu_n` = 0) has no effect while `sel_a_n` is 1. The current address and read data are kept.
- R4: Either strobe, taken while the device is selected, loads `addr_in` as the new burst start. The controller strobe wins when both strobes are low.
- R5: With `lin_order` = 1, each cycle with `step_n` = 0 and no strobe moves the low two address bits to (start + beat) mod 4.
- R6: With `lin_order` = 0, the low two address bits follow start XOR beat.
- R7: After the fourth beat, the next step returns to the start word. The upper address bits never change during a burst.
- R8: With `wr_mst_n` = 0, lane i (bits 9i+8 down to 9i, where bit 9i+8 is that lane's parity bit) is written only when `lane_wr_n[i]` = 0. All other lanes keep their contents.
- R9: With `wr_all_n` = 0, all four lanes are written, whatever `wr_mst_n` and `lane_wr_n` hold.
- R10: With `wr_mst_n` = 1 and `wr_all_n` = 1, the cycle is a read. Nothing is written, whatever `lane_wr_n` holds.
- R11: `rd_en` is 1 only in a read cycle while `out_en_n` is 0. It follows `out_en_n` without waiting for a clock edge. `rd_data` is 0 whenever `rd_en` is 0, which includes the cycle after every write.
- R12: While `rst_n` is low, and after reset until the first selected strobe, the block is idle and `rd_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_in | input | 6 | External word address |
| wdata | input | 36 | Write data, four 9-bit lanes |
| sel_a_n | input | 1 | Primary select, active low |
| sel_b | input | 1 | Secondary select, active high |
| sel_c_n | input | 1 | Secondary select, active low |
| strb_cpu_n | input | 1 | Processor-side address strobe, active low |
| strb_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| wr_mst_n | input | 1 | Master enable for the lane writes, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| lin_order | input | 1 | Burst order: 1 selects linear, 0 selects interleaved |
| rd_data | output | 36 | Read data, 0 when not driven |
| rd_en | output | 1 | High while `rd_data` is driven |

## Verification
A wrong beat counter or start offset shows up on `rd_data` in the first cycle after the faulty step. The data read comes from a neighbouring word in the same group of four, so every offset in both orders is stepped through a full wrap. A state machine stuck in the wrong state shows up as `rd_en` asserted after a write or a deselect, or missing after a read, at the first edge that follows. A wrong lane mask stays hidden until the word is read back, so each write is followed at once by a read of the same address.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } sbs_state_t;

    localparam int BEAT_W = 2;

    // Low address bits for a given start offset and beat count.
    function automatic logic [BEAT_W-1:0] beat_addr(
        input logic [BEAT_W-1:0] start,
        input logic [BEAT_W-1:0] beat,
        input logic              lin
    );
        logic [BEAT_W-1:0] res;
        if (lin) res = start + beat;
        else     res = start ^ beat;
        return res;
    endfunction

endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
    import sbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_a_n,
    input  logic       sel_b,
    input  logic       sel_c_n,
    input  logic       strb_cpu_n,
    input  logic       strb_ctl_n,
    input  logic       step_n,
    input  logic       wr_mst_n,
    input  logic       wr_all_n,
    output sbs_state_t state,
    output logic       load,
    output logic       adv,
    output logic       wr_now
);

    sbs_state_t state_nxt;
    logic       selected;
    logic       strobe;
    logic       is_wr;

    always_comb begin
        selected = !sel_a_n && sel_b && !sel_c_n;
        // controller strobe always acts; processor strobe needs primary select
        strobe   = !strb_ctl_n || (!strb_cpu_n && !sel_a_n);
        is_wr    = !wr_all_n || !wr_mst_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (strobe && selected)
                    state_nxt = is_wr ? ST_WRITE : ST_READ;
            end
            ST_READ, ST_WRITE: begin
                if (strobe && !selected) state_nxt = ST_IDLE;
                else                     state_nxt = is_wr ? ST_WRITE : ST_READ;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load   = strobe && selected;
        adv    = !strobe && !step_n && (state != ST_IDLE);
        wr_now = (state_nxt == ST_WRITE);
    end

endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
    import sbs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              adv,
    input  logic              lin,
    input  logic [BEAT_W-1:0] ext_lo,
    output logic [BEAT_W-1:0] cur_lo,
    output logic [BEAT_W-1:0] nxt_lo
);

    logic [BEAT_W-1:0] start_q;
    logic [BEAT_W-1:0] beat_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            beat_q  <= '0;
        end else if (load) begin
            start_q <= ext_lo;
            beat_q  <= '0;
        end else if (adv) begin
            beat_q  <= beat_q + 1'b1;
        end
    end

    always_comb begin
        cur_lo = beat_addr(start_q, beat_q, lin);
        if (load)     nxt_lo = ext_lo;
        else if (adv) nxt_lo = beat_addr(start_q, beat_q + 1'b1, lin);
        else          nxt_lo = cur_lo;
    end

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic [LANES-1:0] lane_we,
    input  logic [AW-1:0]    waddr,
    input  logic [DW-1:0]    wdata,
    input  logic [AW-1:0]    raddr,
    output logic [DW-1:0]    rdata
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end

endmodule

// File: rtl/sbs_top.sv
module sbs_top
    import sbs_pkg::*;
#(
    parameter int DEPTH  = 64,
    parameter int LANES  = 4,
    parameter int LANE_W = 9,
    localparam int AW    = $clog2(DEPTH),
    localparam int DW    = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    addr_in,
    input  logic [DW-1:0]    wdata,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             sel_c_n,
    input  logic             strb_cpu_n,
    input  logic             strb_ctl_n,
    input  logic             step_n,
    input  logic             wr_mst_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  logic             wr_all_n,
    input  logic             out_en_n,
    input  logic             lin_order,
    output logic [DW-1:0]    rd_data,
    output logic             rd_en
);

    sbs_state_t        state;
    logic              load;
    logic              adv;
    logic              wr_now;
    logic [BEAT_W-1:0] cur_lo;
    logic [BEAT_W-1:0] nxt_lo;
    logic [AW-1:0]     upper_q;
    logic [AW-1:0]     addr_q;
    logic [AW-1:0]     addr_nxt;
    logic [LANES-1:0]  lane_we;
    logic [DW-1:0]     arr_q;

    sbs_ctrl i_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_a_n    (sel_a_n),
        .sel_b      (sel_b),
        .sel_c_n    (sel_c_n),
        .strb_cpu_n (strb_cpu_n),
        .strb_ctl_n (strb_ctl_n),
        .step_n     (step_n),
        .wr_mst_n   (wr_mst_n),
        .wr_all_n   (wr_all_n),
        .state      (state),
        .load       (load),
        .adv        (adv),
        .wr_now     (wr_now)
    );

    sbs_burst i_burst (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .adv    (adv),
        .lin    (lin_order),
        .ext_lo (addr_in[BEAT_W-1:0]),
        .cur_lo (cur_lo),
        .nxt_lo (nxt_lo)
    );

    // upper address bits change only on a load
    always_ff @(posedge clk) begin
        if (!rst_n)    upper_q <= '0;
        else if (load) upper_q <= addr_in;
    end

    always_comb begin
        addr_q   = {upper_q[AW-1:BEAT_W], cur_lo};
        addr_nxt = load ? addr_in : {upper_q[AW-1:BEAT_W], nxt_lo};
        if (!wr_now)        lane_we = '0;
        else if (!wr_all_n) lane_we = '1;
        else if (!wr_mst_n) lane_we = ~lane_wr_n;
        else                lane_we = '0;
    end

    sbs_array #(
        .DEPTH  (DEPTH),
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) i_array (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (addr_nxt),
        .wdata   (wdata),
        .raddr   (addr_q),
        .rdata   (arr_q)
    );

    always_comb begin
        rd_en   = (state == ST_READ) && !out_en_n;
        rd_data = rd_en ? arr_q : '0;
    end

endmodule

// File: rtl/sbs_checker.sv
module sbs_checker #(
    parameter int AW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          strb_ctl_n,
    input logic          strb_cpu_n,
    input logic          sel_a_n,
    input logic          sel_b,
    input logic          sel_c_n,
    input logic          step_n,
    input logic          lin_order,
    input logic          rd_en,
    input logic          adv,
    input logic          wr_now,
    input logic [AW-1:0] addr_q
);

    // R2
    desel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_ctl_n && (sel_a_n || !sel_b || sel_c_n)) |=> !rd_en);

    // R3
    cpu_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strb_cpu_n && sel_a_n && strb_ctl_n && step_n) |=> $stable(addr_q));

    // R5
    lin_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && lin_order) |=> (!lin_order || addr_q[1:0] == $past(addr_q[1:0]) + 2'd1));

    // R7
    no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> addr_q[AW-1:2] == $past(addr_q[AW-1:2]));

    // R11
    write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_now |=> !rd_en);

endmodule

bind sbs_top sbs_checker #(.AW(AW)) i_sbs_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb_ctl_n (strb_ctl_n),
    .strb_cpu_n (strb_cpu_n),
    .sel_a_n    (sel_a_n),
    .sel_b      (sel_b),
    .sel_c_n    (sel_c_n),
    .step_n     (step_n),
    .lin_order  (lin_order),
    .rd_en      (rd_en),
    .adv        (adv),
    .wr_now     (wr_now),
    .addr_q     (addr_q)
);

// File: tb/test_sbs_top.sv
`timescale 1ns/100ps
module test_sbs_top;

    localparam int AW = 6;
    localparam int DW = 36;
    localparam int NW = 64;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr_in;
    logic [DW-1:0] wdata;
    logic          sel_a_n, sel_b, sel_c_n;
    logic          strb_cpu_n, strb_ctl_n, step_n;
    logic          wr_mst_n, wr_all_n, out_en_n, lin_order;
    logic [3:0]    lane_wr_n;
    logic [DW-1:0] rd_data;
    logic          rd_en;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] model [NW];

    always #2.5 clk = ~clk;

    sbs_top i_sbs_top (
        .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .wdata(wdata),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strb_cpu_n(strb_cpu_n), .strb_ctl_n(strb_ctl_n), .step_n(step_n),
        .wr_mst_n(wr_mst_n), .lane_wr_n(lane_wr_n), .wr_all_n(wr_all_n),
        .out_en_n(out_en_n), .lin_order(lin_order),
        .rd_data(rd_data), .rd_en(rd_en)
    );

    // {addr, lane_wr_n, wr_mst_n, wr_all_n, data}
    localparam logic [47:0] VEC [9] = '{
        {6'd40, 4'b1110, 1'b0, 1'b1, 36'hA_BCDE_F012},
        {6'd41, 4'b0101, 1'b0, 1'b1, 36'h1_2345_6789},
        {6'd42, 4'b1010, 1'b0, 1'b1, 36'hF_0F0F_0F0F},
        {6'd43, 4'b0111, 1'b0, 1'b1, 36'h8_0000_0001},
        {6'd40, 4'b1101, 1'b0, 1'b1, 36'h5_5555_5555},
        {6'd44, 4'b1111, 1'b1, 1'b0, 36'h3_C3C3_C3C3},
        {6'd45, 4'b0000, 1'b1, 1'b0, 36'hE_EEEE_EEEE},
        {6'd46, 4'b0000, 1'b1, 1'b1, 36'h7_7777_7777},
        {6'd47, 4'b1111, 1'b0, 1'b1, 36'h6_6666_6666}
    };

    task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic quiet();
        strb_cpu_n = 1'b1; strb_ctl_n = 1'b1; step_n = 1'b1;
        wr_mst_n = 1'b1; wr_all_n = 1'b1; lane_wr_n = 4'b1111;
    endtask

    function automatic logic [DW-1:0] patt(input int a);
        return 36'h9_8765_4321 ^ (36'(a) * 36'h0_0103_0507);
    endfunction

    task automatic wr(input int a, input logic [DW-1:0] d, input logic [3:0] ln,
                      input logic mst, input logic gw, input bit chk);
        addr_in = AW'(a); wdata = d; strb_ctl_n = 1'b0;
        lane_wr_n = ln; wr_mst_n = mst; wr_all_n = gw;
        tick();
        quiet();
        for (int i = 0; i < 4; i++)
            if (!gw || (!mst && !ln[i])) model[a][i*9 +: 9] = d[i*9 +: 9];
        if (chk) check("R11 drive in write/read cycle", {rd_en, 36'd0},
                       {(mst && gw), 36'd0});
    endtask

    task automatic rd(input int a, input string req);
        addr_in = AW'(a); strb_ctl_n = 1'b0;
        tick();
        quiet();
        check(req, {rd_en, rd_data}, {1'b1, model[a]});
    endtask

    initial begin
        rst_n = 1'b0; addr_in = '0; wdata = '0;
        sel_a_n = 1'b0; sel_b = 1'b1; sel_c_n = 1'b0;
        out_en_n = 1'b0; lin_order = 1'b1;
        quiet();
        repeat (3) tick();
        check("R12 idle in reset", {rd_en, rd_data}, {1'b0, 36'd0});
        rst_n = 1'b1;
        tick();
        check("R12 idle after reset", {rd_en, rd_data}, {1'b0, 36'd0});

        for (int a = 0; a < NW; a++) wr(a, patt(a), 4'b0000, 1'b0, 1'b1, 1'b0);
        rd(5, "R1 flow-through read");

        // R8 R9 R10: table walk, each write read back at once
        for (int v = 0; v < 9; v++) begin
            wr(int'(VEC[v][47:42]), VEC[v][35:0], VEC[v][41:38], VEC[v][37], VEC[v][36], 1'b1);
            rd(int'(VEC[v][47:42]), "R8/R9/R10 read back after lane write");
        end

        // R5 R6 R7: both orders, all offsets, full wrap
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 4; s++) begin
                lin_order = (m == 0);
                rd(8 + s, "R4 burst start");
                for (int k = 1; k <= 4; k++) begin
                    int lo;
                    lo = (m == 0) ? ((s + k) % 4) : (s ^ (k % 4));
                    step_n = 1'b0;
                    tick();
                    quiet();
                    check(m == 0 ? "R5 linear beat / R7 wrap" : "R6 interleaved beat / R7 wrap",
                          {rd_en, rd_data}, {1'b1, model[8 + lo]});
                end
            end
        end
        lin_order = 1'b1;

        // R3: processor strobe ignored with primary select high
        rd(20, "R4 start");
        sel_a_n = 1'b1; strb_cpu_n = 1'b0; addr_in = 6'd21;
        tick();
        quiet(); sel_a_n = 1'b0;
        check("R3 processor strobe ignored", {rd_en, rd_data}, {1'b1, model[20]});

        // R4: processor strobe loads when selected; controller wins when both low
        strb_cpu_n = 1'b0; addr_in = 6'd21;
        tick();
        quiet();
        check("R4 processor strobe load", {rd_en, rd_data}, {1'b1, model[21]});
        strb_cpu_n = 1'b0; strb_ctl_n = 1'b0; addr_in = 6'd22;
        tick();
        quiet();
        check("R4 both strobes", {rd_en, rd_data}, {1'b1, model[22]});

        // R2: deselect via controller strobe
        sel_b = 1'b0; strb_ctl_n = 1'b0;
        tick();
        quiet(); sel_b = 1'b1;
        check("R2 deselect sel_b", {rd_en, rd_data}, {1'b0, 36'd0});
        tick();
        check("R2 stays idle", {rd_en, rd_data}, {1'b0, 36'd0});
        rd(23, "R2 reselect");
        sel_c_n = 1'b1; strb_ctl_n = 1'b0;
        tick();
        quiet(); sel_c_n = 1'b0;
        check("R2 deselect sel_c_n", {rd_en, rd_data}, {1'b0, 36'd0});

        // R11: output enable acts without a clock edge
        rd(24, "R11 read");
        #0.5 out_en_n = 1'b1;
        #0.5 check("R11 output enable off", {rd_en, rd_data}, {1'b0, 36'd0});
        out_en_n = 1'b0;
        #0.5 check("R11 output enable on", {rd_en, rd_data}, {1'b1, model[24]});

        // R9: global write beats disabled lanes; R10 ignores lane enables
        wr(30, 36'hD_1D1D_1D1D, 4'b1111, 1'b1, 1'b0, 1'b1);
        rd(30, "R9 global write");
        wr(31, 36'h0_0000_0000, 4'b0000, 1'b1, 1'b1, 1'b1);
        rd(31, "R10 master high no write");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule